// File: doc/BRIEF.md
# Cascadable serial configuration memory

This block is the readout side of a serial memory that supplies a bitstream to an FPGA that loads itself in master serial mode. The image is fixed at elaboration through a parameter. The FPGA's configuration clock drives `clk_i`, and the serial output `data_o` drives the FPGA's serial data input. While the device is enabled, one stored bit is presented per clock, starting at bit 0 of the image. The output enable `data_oe_o` marks the cycles in which the pin is actively driven. In all other cycles the pin is high-impedance.

A combined reset/output-enable pin and an active-low chip enable gate both the address counter and the output driver. When the image is used up, the block releases its data pin and pulls its cascade output low. That output drives the chip enable of the next memory, so several devices can share one data line in a chain.

At power-up an asynchronous reset clears the block. A power-on sequence then holds the counter at zero and pulls the open-drain ready indicator low for a set number of clocks.

Top module: `cfg_serial_rom`

## Requirements
- R1: While `rst_oe_i` equals `RST_ACTIVE_HIGH` (the reset level), `data_oe_o` is 0 in that same cycle whatever `ce_n_i` is. The next rising edge returns the read position to bit 0 and sets `ceo_n_o` to 1.
- R2: While `ce_n_i` is 1, `data_oe_o` is 0 and the read position is frozen. When `ce_n_i` returns to 0, readout resumes at the bit that was pending.
- R3: The device is enabled when all of these hold: the power-on sequence is complete, the reset level is absent, `ce_n_i` is 0 and the image is not exhausted. While enabled, `data_oe_o` is 1 and `data_o` equals `IMAGE[pos]`. Position 0 (`IMAGE[0]`, the LSB) is presented first. While disabled, `data_o` is 0.
- R4: Each rising edge of `clk_i` while enabled moves the read position forward by one bit.
- R5: On the rising edge that ends the cycle in which `IMAGE[NUM_BITS-1]` is presented, `ceo_n_o` goes to 0 and `data_oe_o` goes to 0. Both stay there until the reset level or a power-on reset.
- R6: While `por_n_i` is 0, asynchronously and without a clock: `ready_pull_o` is 1, `ceo_n_o` is 1, `data_oe_o` is 0, and the read position is 0.
- R7: After `por_n_i` rises, `ready_pull_o` stays 1 through the first `POR_CYCLES+1` rising edges. It drops to 0 on edge `POR_CYCLES+2` (two synchronizer stages followed by `POR_CYCLES` counts) and stays 0. Until then, `data_oe_o` is 0 even if the other inputs would enable the device.
- R8: If the reset level is present on the edge that would consume the last bit, the reset takes priority. `ceo_n_o` stays 1 and the next cycle presents `IMAGE[0]`.
- R9: In a chain where device B's `ce_n_i` is driven by device A's `ceo_n_o`, B presents its own bit 0 in the cycle right after A releases the line. A device built with `RST_ACTIVE_HIGH=0` treats a low `rst_oe_i` as its reset level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Configuration clock from the FPGA; read position advances on rising edges |
| por_n_i | input | 1 | Asynchronous active-low power-on reset |
| rst_oe_i | input | 1 | Combined reset / output-enable pin; reset level set by `RST_ACTIVE_HIGH` |
| ce_n_i | input | 1 | Active-low chip enable; driven by the previous device's `ceo_n_o` in a chain |
| data_o | output | 1 | Serial data bit (0 when not driven) |
| data_oe_o | output | 1 | 1 when `data_o` is driven, 0 for high-impedance |
| ceo_n_o | output | 1 | Active-low cascade output; 0 once the image is exhausted |
| ready_pull_o | output | 1 | 1 while the open-drain ready pin is pulled low (power-on sequence running) |

## Verification
Two functions can fall on the same rising edge: the reset level clearing the counter, and the end-of-image detection flagging exhaustion. The bench provokes this by raising the reset pin in the cycle where the last image bit is on the line. The result is judged by `ceo_n_o` staying high, the next device staying released, and bit 0 reappearing one cycle later. A second overlap is the end of the power-on count landing on an edge where every other input already enables the device. That case is judged by the first driven bit showing up on exactly edge `POR_CYCLES+2`, never earlier.

// File: rtl/cfg_rom_pkg.sv
package cfg_rom_pkg;

  // Control word passed from the gating logic to the address counter.
  typedef struct packed {
    logic clear;  // return position to zero, re-arm cascade output
    logic run;    // step one bit forward
  } rom_ctrl_t;

  // Reset level decode of the combined reset / output-enable pin.
  function automatic logic rst_level(input logic pin, input bit active_high);
    return (pin == active_high);
  endfunction

endpackage

// File: rtl/cfg_rom_por.sv
module cfg_rom_por #(
  parameter int POR_CYCLES = 8
) (
  input  logic clk_i,
  input  logic por_n_i,
  output logic rst_n_o,
  output logic por_done_o
);

  localparam int CW = (POR_CYCLES < 1) ? 1 : $clog2(POR_CYCLES + 1);
  localparam logic [CW-1:0] CNT_END = CW'(POR_CYCLES);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk_i or negedge por_n_i) begin
    if (!por_n_i) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];

  always_comb begin
    cnt_en = (cnt_q != CNT_END);
    cnt_d  = cnt_q + CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_n_o) begin
    if (!rst_n_o)    cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign por_done_o = (cnt_q == CNT_END);

endmodule

// File: rtl/cfg_rom_addr.sv
module cfg_rom_addr
  import cfg_rom_pkg::*;
#(
  parameter int NUM_BITS = 64,
  parameter int AW       = 6
) (
  input  logic          clk_i,
  input  logic          rst_n_i,
  input  rom_ctrl_t     ctrl_i,
  output logic [AW-1:0] addr_o,
  output logic          done_o
);

  localparam logic [AW-1:0] LAST = AW'(NUM_BITS - 1);

  logic [AW-1:0] addr_q, addr_d;
  logic          done_q, done_d;
  logic          upd;

  // Clear has priority over a step on the same edge.
  always_comb begin
    addr_d = addr_q;
    done_d = done_q;
    upd    = ctrl_i.clear | ctrl_i.run;
    if (ctrl_i.clear) begin
      addr_d = '0;
      done_d = 1'b0;
    end else if (ctrl_i.run) begin
      if (addr_q == LAST) done_d = 1'b1;
      else                addr_d = addr_q + AW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      addr_q <= '0;
      done_q <= 1'b0;
    end else if (upd) begin
      addr_q <= addr_d;
      done_q <= done_d;
    end
  end

  assign addr_o = addr_q;
  assign done_o = done_q;

endmodule

// File: rtl/cfg_rom_store.sv
module cfg_rom_store #(
  parameter int                  NUM_BITS = 64,
  parameter int                  AW       = 6,
  parameter logic [NUM_BITS-1:0] IMAGE    = '0
) (
  input  logic [AW-1:0] addr_i,
  output logic          bit_o
);

  generate
    if ((1 << AW) == NUM_BITS) begin : g_full
      always_comb bit_o = IMAGE[addr_i];
    end else begin : g_partial
      always_comb begin
        bit_o = 1'b0;
        for (int i = 0; i < NUM_BITS; i++) begin
          if (addr_i == AW'(i)) bit_o = IMAGE[i];
        end
      end
    end
  endgenerate

endmodule

// File: rtl/cfg_serial_rom.sv
module cfg_serial_rom
  import cfg_rom_pkg::*;
#(
  parameter int                  NUM_BITS        = 64,
  parameter logic [NUM_BITS-1:0] IMAGE           = 64'hA5C3_0F96_1E2D_7B48,
  parameter int                  POR_CYCLES      = 8,
  parameter bit                  RST_ACTIVE_HIGH = 1'b1
) (
  input  logic clk_i,
  input  logic por_n_i,
  input  logic rst_oe_i,
  input  logic ce_n_i,
  output logic data_o,
  output logic data_oe_o,
  output logic ceo_n_o,
  output logic ready_pull_o
);

  localparam int AW = (NUM_BITS > 1) ? $clog2(NUM_BITS) : 1;

  logic          rst_n_w;
  logic          por_done_w;
  logic          rst_lvl_w;
  logic          enable_w;
  logic          done_w;
  logic          bit_w;
  logic [AW-1:0] addr_w;
  rom_ctrl_t     ctrl_w;

  cfg_rom_por #(.POR_CYCLES(POR_CYCLES)) u_por (
    .clk_i      (clk_i),
    .por_n_i    (por_n_i),
    .rst_n_o    (rst_n_w),
    .por_done_o (por_done_w)
  );

  always_comb begin
    rst_lvl_w    = rst_level(rst_oe_i, RST_ACTIVE_HIGH);
    enable_w     = por_done_w & ~rst_lvl_w & ~ce_n_i & ~done_w;
    ctrl_w.clear = rst_lvl_w | ~por_done_w;
    ctrl_w.run   = enable_w;
  end

  cfg_rom_addr #(.NUM_BITS(NUM_BITS), .AW(AW)) u_addr (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_w),
    .ctrl_i  (ctrl_w),
    .addr_o  (addr_w),
    .done_o  (done_w)
  );

  cfg_rom_store #(.NUM_BITS(NUM_BITS), .AW(AW), .IMAGE(IMAGE)) u_store (
    .addr_i (addr_w),
    .bit_o  (bit_w)
  );

  assign data_oe_o    = enable_w;
  assign data_o       = enable_w & bit_w;
  assign ceo_n_o      = ~done_w;
  assign ready_pull_o = ~por_done_w;

endmodule

// File: rtl/cfg_serial_rom_chk.sv
module cfg_serial_rom_chk #(
  parameter int NUM_BITS        = 64,
  parameter bit RST_ACTIVE_HIGH = 1'b1,
  parameter int AW              = 6
) (
  input logic          clk_i,
  input logic          por_n_i,
  input logic          rst_oe_i,
  input logic          ce_n_i,
  input logic          data_oe_o,
  input logic          ceo_n_o,
  input logic          ready_pull_o,
  input logic [AW-1:0] addr
);

  localparam logic [AW-1:0] LAST = AW'(NUM_BITS - 1);
  logic rst_lvl;
  assign rst_lvl = (rst_oe_i == RST_ACTIVE_HIGH);

  a_r1_reset_tristate: assert property (@(posedge clk_i) disable iff (!por_n_i)
    rst_lvl |-> !data_oe_o);

  a_r1_reset_clears: assert property (@(posedge clk_i) disable iff (!por_n_i)
    rst_lvl |=> (addr == '0) && ceo_n_o);

  a_r2_ce_blocks: assert property (@(posedge clk_i) disable iff (!por_n_i)
    ce_n_i |-> !data_oe_o);

  a_r2_ce_freeze: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (ce_n_i && !rst_lvl && !ready_pull_o) |=> $stable(addr));

  a_r4_advance: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (data_oe_o && addr != LAST) |=> addr == $past(addr) + AW'(1));

  a_r5_done_releases: assert property (@(posedge clk_i) disable iff (!por_n_i)
    !ceo_n_o |-> !data_oe_o);

  a_r5_ceo_sticky: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (!ceo_n_o && !rst_lvl) |=> !ceo_n_o);

  a_r7_por_holds: assert property (@(posedge clk_i) disable iff (!por_n_i)
    ready_pull_o |-> (addr == '0) && !data_oe_o);

  a_r7_ready_stays: assert property (@(posedge clk_i) disable iff (!por_n_i)
    !ready_pull_o |=> !ready_pull_o);

  a_r8_last_reset: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (rst_lvl && addr == LAST && ceo_n_o) |=> ceo_n_o);

endmodule

bind cfg_serial_rom cfg_serial_rom_chk #(
  .NUM_BITS(NUM_BITS), .RST_ACTIVE_HIGH(RST_ACTIVE_HIGH), .AW(AW)
) u_chk (
  .clk_i        (clk_i),
  .por_n_i      (por_n_i),
  .rst_oe_i     (rst_oe_i),
  .ce_n_i       (ce_n_i),
  .data_oe_o    (data_oe_o),
  .ceo_n_o      (ceo_n_o),
  .ready_pull_o (ready_pull_o),
  .addr         (addr_w)
);

// File: tb/cfg_serial_rom_bench.sv
module cfg_serial_rom_bench;

  localparam int          CLK_PERIOD = 10;
  localparam int          NB_A  = 64;
  localparam logic [63:0] IMG_A = 64'hA5C3_0F96_1E2D_7B48;
  localparam int          P_A   = 8;
  localparam int          NB_B  = 16;
  localparam logic [15:0] IMG_B = 16'hC35A;
  localparam int          P_B   = 3;

  logic clk = 1'b0;
  logic por_n, rst_pin, ce_n;
  logic a_data, a_oe, a_ceo_n, a_rdy;
  logic b_data, b_oe, b_ceo_n, b_rdy;
  int   vectors = 0;
  int   fails   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_serial_rom u_cfg_serial_rom (
    .clk_i(clk), .por_n_i(por_n), .rst_oe_i(rst_pin), .ce_n_i(ce_n),
    .data_o(a_data), .data_oe_o(a_oe), .ceo_n_o(a_ceo_n), .ready_pull_o(a_rdy)
  );

  // Second device in the chain, active-low reset level.
  cfg_serial_rom #(
    .NUM_BITS(NB_B), .IMAGE(IMG_B), .POR_CYCLES(P_B), .RST_ACTIVE_HIGH(1'b0)
  ) u_next (
    .clk_i(clk), .por_n_i(por_n), .rst_oe_i(~rst_pin), .ce_n_i(a_ceo_n),
    .data_o(b_data), .data_oe_o(b_oe), .ceo_n_o(b_ceo_n), .ready_pull_o(b_rdy)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic restart();
    @(negedge clk); rst_pin = 1'b1; ce_n = 1'b0;
    @(negedge clk); rst_pin = 1'b0;
    #1;
  endtask

  task automatic t_por_seq();
    @(negedge clk); por_n = 1'b1; rst_pin = 1'b0; ce_n = 1'b0;
    for (int k = 1; k <= P_A + 2; k++) begin
      @(negedge clk); #1;
      chk("R7 ready A", a_rdy, (k < P_A + 2));
      chk("R7 oe held A", a_oe, (k == P_A + 2));
      chk("R7 ready B", b_rdy, (k < P_B + 2));
    end
    chk("R3 first bit", a_data, IMG_A[0]);
  endtask

  task automatic t_readout();
    restart();
    for (int i = 0; i < NB_A; i++) begin
      chk("R3 oe A", a_oe, 1'b1);
      chk("R4 data A", a_data, IMG_A[i]);
      chk("R5 ceo high", a_ceo_n, 1'b1);
      chk("R9 B quiet", b_oe, 1'b0);
      step(1);
    end
    chk("R5 ceo low", a_ceo_n, 1'b0);
    chk("R5 released", a_oe, 1'b0);
    for (int i = 0; i < NB_B; i++) begin
      chk("R9 oe B", b_oe, 1'b1);
      chk("R9 data B", b_data, IMG_B[i]);
      step(1);
    end
    chk("R5 ceo B low", b_ceo_n, 1'b0);
    chk("R5 B released", b_oe, 1'b0);
    step(2);
    chk("R5 ceo sticky", a_ceo_n, 1'b0);
  endtask

  task automatic t_ce_pause();
    restart();
    step(5);
    ce_n = 1'b1; #1;
    chk("R2 oe off", a_oe, 1'b0);
    step(3);
    chk("R2 oe still off", a_oe, 1'b0);
    chk("R2 B quiet", b_oe, 1'b0);
    ce_n = 1'b0; #1;
    chk("R2 resume oe", a_oe, 1'b1);
    chk("R2 resume bit5", a_data, IMG_A[5]);
    step(1);
    chk("R2 then bit6", a_data, IMG_A[6]);
  endtask

  task automatic t_reset_mid();
    restart();
    step(10);
    rst_pin = 1'b1; #1;
    chk("R1 oe off ce low", a_oe, 1'b0);
    ce_n = 1'b1; #1;
    chk("R1 oe off ce high", a_oe, 1'b0);
    step(1);
    rst_pin = 1'b0; ce_n = 1'b0; #1;
    chk("R1 restart oe", a_oe, 1'b1);
    chk("R1 restart bit0", a_data, IMG_A[0]);
    restart();
    step(NB_A);
    chk("R1 exhausted", a_ceo_n, 1'b0);
    rst_pin = 1'b1;
    step(1);
    chk("R1 ceo rearmed", a_ceo_n, 1'b1);
    chk("R1 oe off in reset", a_oe, 1'b0);
    rst_pin = 1'b0; #1;
    chk("R1 bit0 after exhaust", a_data, IMG_A[0]);
  endtask

  task automatic t_reset_last();
    restart();
    step(NB_A - 1);
    chk("R8 last bit on line", a_data, IMG_A[NB_A-1]);
    chk("R8 last oe", a_oe, 1'b1);
    rst_pin = 1'b1;
    step(1);
    rst_pin = 1'b0; #1;
    chk("R8 ceo stays high", a_ceo_n, 1'b1);
    chk("R8 B not enabled", b_oe, 1'b0);
    chk("R8 bit0 again", a_data, IMG_A[0]);
    chk("R8 oe again", a_oe, 1'b1);
  endtask

  task automatic t_async_por();
    restart();
    step(NB_A + 3);
    chk("R6 pre-state", a_ceo_n, 1'b0);
    #2; por_n = 1'b0; #1;
    chk("R6 ready pulled", a_rdy, 1'b1);
    chk("R6 ceo high", a_ceo_n, 1'b1);
    chk("R6 oe off", a_oe, 1'b0);
    chk("R6 B ready pulled", b_rdy, 1'b1);
    chk("R6 B oe off", b_oe, 1'b0);
    t_por_seq();
  endtask

  initial begin
    por_n = 1'b0; rst_pin = 1'b1; ce_n = 1'b0;
    #3;
    chk("R6 reset ready", a_rdy, 1'b1);
    chk("R6 reset ceo", a_ceo_n, 1'b1);
    chk("R6 reset oe", a_oe, 1'b0);
    step(2);
    t_por_seq();
    t_readout();
    t_ce_pause();
    t_reset_mid();
    t_reset_last();
    t_async_por();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule